// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag side of a set-associative cache. For every way of every set it keeps an occupied flag, the stored line address, a three-bit permission state and a lock owner (a context number plus a "held" flag). A per-set true-LRU age table picks victims. It holds no data storage. A cache controller issues one command per cycle. The command names an opcode, an address and the side fields that opcode uses. The registered result comes back on the following cycle.

Whether a line can be used depends on its permission, not just on an address match. A read-only line grants loads and instruction fetches but refuses stores. A line whose permission is set to not-present counts as free space: the next allocation may reuse it. A tag match during an access attempt refreshes the line's recency even when the access is refused. Allocation into a full set, allocation of a line that is already present, and lock commands aimed at an absent line raise an error flag and leave all state as it was.

The response path is a two-state machine. ST_IDLE means no result is pending and ST_RESULT means a result is on the outputs. Both states move to ST_RESULT when `cmd_valid` is high in a cycle and to ST_IDLE when it is low, so back-to-back commands keep the machine in ST_RESULT.

Top module: `tagdir_top`

## Requirements
- R1: Opcodes on `cmd_op`: 0 lookup, 1 access, 2 availability, 3 allocate, 4 deallocate, 5 victim probe, 6 set-MRU, 7 set-lock, 8 clear-lock, 9 test-lock, 10 read-by-index, 11 set-permission. A command sampled with `cmd_valid` high gives `rsp_valid` high on the next cycle, and `rsp_valid` is low otherwise. After reset `rsp_valid` is low, every way is empty with permission not-present, and the LRU order of every set has way WAYS-1 as least recent.
- R2: The set count is CACHE_BYTES/WAYS/LINE_BYTES and must exceed one. The set index is the log2(sets) address bits starting at bit IDX_LSB. The low log2(LINE_BYTES) address bits are ignored when addresses are compared.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only, 3 read-write, 4 busy. A lookup hits only when an occupied way of the set stores the line address and its permission is not 0. On a hit, `rsp_way` and `rsp_perm` give that way and its permission.
- R4: Access kinds on `cmd_kind` are 0 load, 1 fetch, 2 store. `rsp_grant` is high only on a hit whose permission is read-write, or read-only with a load or fetch. Every other case is refused.
- R5: An access that hits updates that way to most recently used even when it is refused.
- R6: `rsp_avail` is high when the line is stored in an occupied way of its set (whatever its permission) or when some way of the set is empty or not-present.
- R7: Allocate fills the lowest-numbered empty or not-present way and reports it on `rsp_way`. It stores the line address, sets the permission to invalid and releases the lock. It refreshes recency only when `cmd_touch` is high.
- R8: Allocate with no free way, or of a line that already hits, sets `rsp_err` and changes nothing.
- R9: Deallocate of a hitting line returns its way to empty. Set-permission writes `cmd_perm` to the way storing the line, ignoring its current permission. Writing code 0 makes that way free.
- R10: When no way of the set is free and the line is not stored, the victim probe sets `rsp_vic_ok` and returns the least recently used way's stored address on `rsp_addr`.
- R11: Set-MRU of a hitting line makes it most recently used. Otherwise it has no effect.
- R12: Set-lock stores `cmd_ctx` as the owner of a hitting line and clear-lock releases it. Test-lock gives `rsp_locked` high only when the lock is held and the owner equals `cmd_ctx`. Any of the three on a line that does not hit sets `rsp_err` and changes nothing.
- R13: Read-by-index takes `cmd_addr[log2(sets*WAYS)-1:0]` as set*WAYS+way and returns that way's address on `rsp_addr`. It returns zero when the way is empty, invalid or not-present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode (R1) |
| cmd_addr | input | ADDR_W | Byte address, or flat index for read-by-index |
| cmd_kind | input | 2 | Access kind for access commands |
| cmd_perm | input | 3 | Permission for set-permission |
| cmd_touch | input | 1 | Refresh recency on allocate |
| cmd_ctx | input | CTX_W | Requester context for lock commands |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Line hit |
| rsp_way | output | log2(WAYS) | Hit way, or allocated way |
| rsp_perm | output | 3 | Permission of hit way |
| rsp_grant | output | 1 | Access granted |
| rsp_avail | output | 1 | Room or presence for the line |
| rsp_vic_ok | output | 1 | Victim probe result is meaningful |
| rsp_addr | output | ADDR_W | Victim address or indexed address |
| rsp_locked | output | 1 | Test-lock result |
| rsp_err | output | 1 | Illegal allocate or lock command |

## Verification
The bench uses the default configuration: 12-bit addresses, 256 bytes, 4 ways, 16-byte lines, so 4 sets and 16 ways in all. It keeps a timestamp-based recency model for each set. At this size every flat index is swept, every set is filled past capacity, and every permission is crossed with every access kind. A long pseudo-random command mix can then reach full sets, freed slots, lock contention and refused-access recency updates many times over.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [3:0] {
        OP_LOOKUP   = 4'd0,
        OP_ACCESS   = 4'd1,
        OP_AVAIL    = 4'd2,
        OP_ALLOC    = 4'd3,
        OP_DEALLOC  = 4'd4,
        OP_VICTIM   = 4'd5,
        OP_SETMRU   = 4'd6,
        OP_SETLOCK  = 4'd7,
        OP_CLRLOCK  = 4'd8,
        OP_TESTLOCK = 4'd9,
        OP_READIDX  = 4'd10,
        OP_SETPERM  = 4'd11
    } tdir_op_e;

    typedef enum logic [2:0] {
        PERM_NP   = 3'd0,
        PERM_INV  = 3'd1,
        PERM_RO   = 3'd2,
        PERM_RW   = 3'd3,
        PERM_BUSY = 3'd4
    } tdir_perm_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_STORE = 2'd2
    } tdir_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } tdir_state_e;

endpackage

// File: rtl/tagdir_match.sv
module tagdir_match
    import tagdir_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 12,
    parameter int WAY_W  = 2
) (
    input  logic [WAYS-1:0]   occ,
    input  logic [2:0]        perm [WAYS],
    input  logic [ADDR_W-1:0] tag  [WAYS],
    input  logic [ADDR_W-1:0] line,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic              raw_hit,
    output logic [WAY_W-1:0]  raw_way,
    output logic              free_any,
    output logic [WAY_W-1:0]  free_way
);

    // Scan from the top way down so the lowest qualifying way wins.
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        raw_hit  = 1'b0;
        raw_way  = '0;
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (occ[w] && tag[w] == line) begin
                raw_hit = 1'b1;
                raw_way = WAY_W'(w);
                if (perm[w] != PERM_NP) begin
                    hit     = 1'b1;
                    hit_way = WAY_W'(w);
                end
            end
            if (!occ[w] || perm[w] == PERM_NP) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int SET_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] q_set,
    output logic [WAY_W-1:0] vic_way
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    // Age 0 is most recent, WAYS-1 is least recent; ages in a set form a permutation.
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        vic_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[q_set][w] == OLDEST)
                vic_way = WAY_W'(w);
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set_chk
        logic [WAYS-1:0] oldest_vec;
        always_comb
            for (int w = 0; w < WAYS; w++)
                oldest_vec[w] = (age_q[s][w] == OLDEST);

        // Exactly one least-recent way per set, so the victim is unambiguous.
        assert_single_oldest_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oldest_vec) == 1)
            else $error("set %0d has no unique LRU way", s);

        // A touched way becomes most recent on the following cycle.
        assert_touch_mru_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (touch_en && touch_set == SET_W'(s)) |=> age_q[s][$past(touch_way)] == '0)
            else $error("touched way not most recent in set %0d", s);
    end

endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
    import tagdir_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CACHE_BYTES = 256,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 16,
    parameter int IDX_LSB     = 4,
    parameter int CTX_W       = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [3:0]                cmd_op,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic [1:0]                cmd_kind,
    input  logic [2:0]                cmd_perm,
    input  logic                      cmd_touch,
    input  logic [CTX_W-1:0]          cmd_ctx,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [$clog2(WAYS)-1:0]   rsp_way,
    output logic [2:0]                rsp_perm,
    output logic                      rsp_grant,
    output logic                      rsp_avail,
    output logic                      rsp_vic_ok,
    output logic [ADDR_W-1:0]         rsp_addr,
    output logic                      rsp_locked,
    output logic                      rsp_err
);

    localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int OFS_W = $clog2(LINE_BYTES);

    // ---------------- directory storage ----------------
    logic              occ_q  [SETS][WAYS];
    logic [2:0]        perm_q [SETS][WAYS];
    logic [ADDR_W-1:0] tag_q  [SETS][WAYS];
    logic              lkv_q  [SETS][WAYS];
    logic [CTX_W-1:0]  ctx_q  [SETS][WAYS];

    // ---------------- command decode ----------------
    tdir_op_e          op;
    logic [SET_W-1:0]  set_sel;
    logic [ADDR_W-1:0] line_addr;
    logic [SET_W-1:0]  f_set;
    logic [WAY_W-1:0]  f_way;

    assign op        = tdir_op_e'(cmd_op);
    assign set_sel   = cmd_addr[IDX_LSB +: SET_W];
    assign line_addr = {cmd_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign f_set     = cmd_addr[WAY_W +: SET_W];
    assign f_way     = cmd_addr[WAY_W-1:0];

    logic [WAYS-1:0]   s_occ;
    logic [2:0]        s_perm [WAYS];
    logic [ADDR_W-1:0] s_tag  [WAYS];

    always_comb
        for (int w = 0; w < WAYS; w++) begin
            s_occ[w]  = occ_q[set_sel][w];
            s_perm[w] = perm_q[set_sel][w];
            s_tag[w]  = tag_q[set_sel][w];
        end

    logic             m_hit, m_raw, m_free;
    logic [WAY_W-1:0] m_hit_way, m_raw_way, m_free_way, vic_way;

    tagdir_match #(.WAYS(WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_match (
        .occ      (s_occ),
        .perm     (s_perm),
        .tag      (s_tag),
        .line     (line_addr),
        .hit      (m_hit),
        .hit_way  (m_hit_way),
        .raw_hit  (m_raw),
        .raw_way  (m_raw_way),
        .free_any (m_free),
        .free_way (m_free_way)
    );

    logic [2:0] hit_perm;
    logic       grant_c, avail_c, alloc_ok, alloc_err, lock_op, lock_err;
    logic       touch_en;
    logic [WAY_W-1:0] touch_way;

    assign hit_perm  = s_perm[m_hit_way];
    assign grant_c   = m_hit && (hit_perm == PERM_RW ||
                       (hit_perm == PERM_RO && cmd_kind != KIND_STORE));
    assign avail_c   = m_raw || m_free;
    assign alloc_ok  = cmd_valid && op == OP_ALLOC && !m_hit && m_free;
    assign alloc_err = cmd_valid && op == OP_ALLOC && (m_hit || !m_free);
    assign lock_op   = op == OP_SETLOCK || op == OP_CLRLOCK || op == OP_TESTLOCK;
    assign lock_err  = cmd_valid && lock_op && !m_hit;
    assign touch_en  = (cmd_valid && (op == OP_ACCESS || op == OP_SETMRU) && m_hit)
                     || (alloc_ok && cmd_touch);
    assign touch_way = alloc_ok ? m_free_way : m_hit_way;

    tagdir_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_set (set_sel),
        .touch_way (touch_way),
        .q_set     (set_sel),
        .vic_way   (vic_way)
    );

    // ---------------- state updates ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    occ_q[s][w]  <= 1'b0;
                    perm_q[s][w] <= PERM_NP;
                    tag_q[s][w]  <= '0;
                    lkv_q[s][w]  <= 1'b0;
                    ctx_q[s][w]  <= '0;
                end
        end else if (cmd_valid) begin
            unique case (op)
                OP_ALLOC: if (alloc_ok) begin
                    occ_q[set_sel][m_free_way]  <= 1'b1;
                    tag_q[set_sel][m_free_way]  <= line_addr;
                    perm_q[set_sel][m_free_way] <= PERM_INV;
                    lkv_q[set_sel][m_free_way]  <= 1'b0;
                end
                OP_DEALLOC: if (m_hit) begin
                    occ_q[set_sel][m_hit_way]  <= 1'b0;
                    perm_q[set_sel][m_hit_way] <= PERM_NP;
                    lkv_q[set_sel][m_hit_way]  <= 1'b0;
                end
                OP_SETPERM: if (m_raw)
                    perm_q[set_sel][m_raw_way] <= cmd_perm;
                OP_SETLOCK: if (m_hit) begin
                    lkv_q[set_sel][m_hit_way] <= 1'b1;
                    ctx_q[set_sel][m_hit_way] <= cmd_ctx;
                end
                OP_CLRLOCK: if (m_hit)
                    lkv_q[set_sel][m_hit_way] <= 1'b0;
                default: ;
            endcase
        end
    end

    // ---------------- response FSM ----------------
    tdir_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = cmd_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = cmd_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   rsp_valid = 1'b0;
            ST_RESULT: rsp_valid = 1'b1;
            default:   rsp_valid = 1'b0;
        endcase
    end

    logic [ADDR_W-1:0] idx_addr;
    assign idx_addr = (occ_q[f_set][f_way] && perm_q[f_set][f_way] != PERM_INV
                       && perm_q[f_set][f_way] != PERM_NP) ? tag_q[f_set][f_way] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_perm   <= PERM_NP;
            rsp_grant  <= 1'b0;
            rsp_avail  <= 1'b0;
            rsp_vic_ok <= 1'b0;
            rsp_addr   <= '0;
            rsp_locked <= 1'b0;
            rsp_err    <= 1'b0;
        end else if (cmd_valid) begin
            rsp_hit    <= m_hit;
            rsp_way    <= (op == OP_ALLOC) ? m_free_way : m_hit_way;
            rsp_perm   <= m_hit ? hit_perm : PERM_NP;
            rsp_grant  <= (op == OP_ACCESS) && grant_c;
            rsp_avail  <= avail_c;
            rsp_vic_ok <= (op == OP_VICTIM) && !avail_c;
            rsp_addr   <= (op == OP_VICTIM && !avail_c) ? tag_q[set_sel][vic_way] :
                          (op == OP_READIDX) ? idx_addr : '0;
            rsp_locked <= (op == OP_TESTLOCK) && m_hit && lkv_q[set_sel][m_hit_way]
                          && ctx_q[set_sel][m_hit_way] == cmd_ctx;
            rsp_err    <= alloc_err || lock_err;
        end
    end

    // ---------------- assertions ----------------
    assert_cmd_to_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid) else $error("command without response");

    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid) else $error("response without command");

    assert_grant_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> rsp_hit) else $error("grant on a miss");

    assert_victim_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vic_ok |-> !rsp_avail) else $error("victim offered while room exists");

    assert_alloc_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |=> (occ_q[$past(set_sel)][$past(m_free_way)]
                      && perm_q[$past(set_sel)][$past(m_free_way)] == PERM_INV))
        else $error("allocated way not filled as invalid");

    assert_lock_err_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_locked) |-> !rsp_err) else $error("lock held reported with error");

endmodule

// File: tb/tagdir_top_tb_top.sv
module tagdir_top_tb_top;

    localparam int CLK_P = 10;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [11:0] cmd_addr = '0;
    logic [1:0]  cmd_kind = '0;
    logic [2:0]  cmd_perm = '0;
    logic        cmd_touch = 1'b0;
    logic [3:0]  cmd_ctx = '0;
    logic        rsp_valid, rsp_hit, rsp_grant, rsp_avail, rsp_vic_ok, rsp_locked, rsp_err;
    logic [1:0]  rsp_way;
    logic [2:0]  rsp_perm;
    logic [11:0] rsp_addr;

    always #(CLK_P/2) clk = ~clk;

    tagdir_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_kind(cmd_kind), .cmd_perm(cmd_perm),
        .cmd_touch(cmd_touch), .cmd_ctx(cmd_ctx), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_perm(rsp_perm),
        .rsp_grant(rsp_grant), .rsp_avail(rsp_avail), .rsp_vic_ok(rsp_vic_ok),
        .rsp_addr(rsp_addr), .rsp_locked(rsp_locked), .rsp_err(rsp_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model: occupancy, address, permission, lock, owner, last-touch stamp.
    bit mo [SETS][WAYS];
    int ma [SETS][WAYS];
    int mp [SETS][WAYS];
    bit ml [SETS][WAYS];
    int mc [SETS][WAYS];
    int ms [SETS][WAYS];
    int tick = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int la(input int t, input int s);
        return (t << 6) | (s << 4);
    endfunction

    task automatic run(input int op, input int a, input int kind, input int perm,
                       input bit touch, input int ctx, input string req);
        int s = (a >> 4) & 3;
        int line = a & 'hFF0;
        int hw = -1, rw = -1, fw = -1, vw = 0;
        bit hit, avail, eerr;
        for (int w = 0; w < WAYS; w++) begin
            if (hw < 0 && mo[s][w] && ma[s][w] == line && mp[s][w] != 0) hw = w;
            if (rw < 0 && mo[s][w] && ma[s][w] == line) rw = w;
            if (fw < 0 && (!mo[s][w] || mp[s][w] == 0)) fw = w;
            if (ms[s][w] < ms[s][vw]) vw = w;
        end
        hit   = (hw >= 0);
        avail = (rw >= 0) || (fw >= 0);
        eerr  = (op == 3) ? (hit || fw < 0) : ((op >= 7 && op <= 9) ? !hit : 1'b0);

        cmd_op = 4'(op); cmd_addr = 12'(a); cmd_kind = 2'(kind); cmd_perm = 3'(perm);
        cmd_touch = touch; cmd_ctx = 4'(ctx); cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);

        chk("R1", "rsp_valid", rsp_valid, 1);
        chk(req, "err", rsp_err, eerr);
        case (op)
            0: begin
                chk(req, "hit", rsp_hit, hit);
                if (hit) begin
                    chk(req, "way", rsp_way, hw);
                    chk(req, "perm", rsp_perm, mp[s][hw]);
                end
            end
            1: begin
                chk(req, "hit", rsp_hit, hit);
                chk(req, "grant", rsp_grant,
                    hit && (mp[s][hw] == 3 || (mp[s][hw] == 2 && kind != 2)));
            end
            2: chk(req, "avail", rsp_avail, avail);
            3: if (!eerr) chk(req, "alloc way", rsp_way, fw);
            5: begin
                chk(req, "vic_ok", rsp_vic_ok, !avail);
                if (!avail) chk(req, "victim addr", rsp_addr, ma[s][vw]);
            end
            9: chk(req, "locked", rsp_locked, hit && ml[s][hw] && mc[s][hw] == ctx);
            10: begin
                int fs = (a >> 2) & 3;
                int fwy = a & 3;
                chk(req, "index addr", rsp_addr,
                    (mo[fs][fwy] && mp[fs][fwy] > 1) ? ma[fs][fwy] : 0);
            end
            default: ;
        endcase

        case (op)
            1, 6: if (hit) ms[s][hw] = ++tick;
            3: if (!eerr) begin
                mo[s][fw] = 1; ma[s][fw] = line; mp[s][fw] = 1; ml[s][fw] = 0;
                if (touch) ms[s][fw] = ++tick;
            end
            4: if (hit) begin mo[s][hw] = 0; mp[s][hw] = 0; ml[s][hw] = 0; end
            7: if (hit) begin ml[s][hw] = 1; mc[s][hw] = ctx; end
            8: if (hit) ml[s][hw] = 0;
            11: if (rw >= 0) mp[s][rw] = perm;
            default: ;
        endcase
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned x = 32'h1234_5678;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mo[s][w] = 0; ma[s][w] = 0; mp[s][w] = 0;
                ml[s][w] = 0; mc[s][w] = 0; ms[s][w] = -w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset rsp_valid", rsp_valid, 0);

        // R13 / R1: every way empty after reset
        for (int i = 0; i < SETS * WAYS; i++) run(10, i, 0, 0, 0, 0, "R13");
        for (int s = 0; s < SETS; s++) run(2, la(1, s), 0, 0, 0, 0, "R6");
        for (int s = 0; s < SETS; s++) run(0, la(1, s), 0, 0, 0, 0, "R3");

        // R7 / R8 / R10: fill every set past capacity
        for (int s = 0; s < SETS; s++) begin
            for (int t = 0; t < WAYS; t++) run(3, la(t + 1, s), 0, 0, (t == 3), 0, "R7");
            run(2, la(9, s), 0, 0, 0, 0, "R6");
            run(2, la(2, s), 0, 0, 0, 0, "R6");
            run(5, la(9, s), 0, 0, 0, 0, "R10");
            run(3, la(9, s), 0, 0, 0, 0, "R8");
            run(3, la(2, s), 0, 0, 0, 0, "R8");
            run(0, la(9, s), 0, 0, 0, 0, "R8");
        end
        for (int i = 0; i < SETS * WAYS; i++) run(10, i, 0, 0, 0, 0, "R13");

        // R3 / R4: every permission against every access kind
        foreach (mp[0][k]) begin end
        for (int pi = 0; pi < 5; pi++) begin
            int p = (pi + 1) % 5;
            run(11, la(1, 0), 0, p, 0, 0, "R9");
            run(0, la(1, 0), 0, 0, 0, 0, "R3");
            for (int k = 0; k < 3; k++) run(1, la(1, 0), k, 0, 0, 0, "R4");
        end
        run(2, la(9, 0), 0, 0, 0, 0, "R6");
        run(3, la(9, 0), 0, 0, 0, 0, "R9");

        // R5: refused access still refreshes recency
        run(1, la(3, 1), 2, 0, 0, 0, "R5");
        run(5, la(9, 1), 0, 0, 0, 0, "R5");
        // R11: set-MRU reshapes the victim order
        for (int t = 0; t < WAYS; t++) begin
            run(6, la(t + 1, 1), 0, 0, 0, 0, "R11");
            run(5, la(9, 1), 0, 0, 0, 0, "R11");
        end
        run(6, la(9, 1), 0, 0, 0, 0, "R11");
        run(5, la(9, 1), 0, 0, 0, 0, "R11");

        // R2: offset bits ignored, set bits select
        run(0, la(2, 2) | 5, 0, 0, 0, 0, "R2");
        run(0, la(2, 2) | 15, 0, 0, 0, 0, "R2");
        run(0, la(9, 2) | 3, 0, 0, 0, 0, "R2");

        // R12: locks
        run(7, la(1, 2), 0, 0, 0, 5, "R12");
        run(9, la(1, 2), 0, 0, 0, 5, "R12");
        run(9, la(1, 2), 0, 0, 0, 6, "R12");
        run(8, la(1, 2), 0, 0, 0, 0, "R12");
        run(9, la(1, 2), 0, 0, 0, 5, "R12");
        run(7, la(9, 2), 0, 0, 0, 3, "R12");
        run(9, la(9, 2), 0, 0, 0, 3, "R12");
        run(8, la(9, 2), 0, 0, 0, 0, "R12");

        // R9: deallocate and reuse
        run(4, la(2, 3), 0, 0, 0, 0, "R9");
        run(0, la(2, 3), 0, 0, 0, 0, "R9");
        run(10, 13, 0, 0, 0, 0, "R9");
        run(2, la(9, 3), 0, 0, 0, 0, "R9");
        run(3, la(9, 3), 0, 0, 1, 0, "R9");
        run(11, la(2, 0), 0, 3, 0, 0, "R9");
        run(11, la(3, 0), 0, 2, 0, 0, "R9");
        run(11, la(4, 0), 0, 4, 0, 0, "R9");
        for (int i = 0; i < SETS * WAYS; i++) run(10, i, 0, 0, 0, 0, "R13");

        // Mixed pseudo-random sweep over all opcodes
        for (int n = 0; n < 1500; n++) begin
            int op, a;
            x = x * 1103515245 + 12345;
            op = int'((x >> 16) % 12);
            a  = (op == 10) ? int'((x >> 8) % 16)
                            : (la(int'((x >> 8) % 5) + 1, int'((x >> 4) % 4)) | int'(x % 16));
            run(op, a, int'((x >> 20) % 3), int'((x >> 24) % 5), x[27],
                int'((x >> 28) % 4), "R1");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule